// File: doc/BRIEF.md
# Byte-Lane Memory Bank Controller

This block connects a processor-side request port to a 16-bit memory built from two byte-wide banks. One bank holds the even byte addresses and carries data bits 7:0. The other holds the odd byte addresses and carries bits 15:8. Each request carries a 20-bit byte address, a byte or word size, a direction and write data. The block turns it into one or two bank cycles. For each cycle it drives the word address shared by both banks, two active-low bank enables, the lane-steered write data and a read or write strobe.

Each bank cycle has two phases. The first is an address clock and the second is a data clock. The data clock repeats while the memory holds its ready input low. A word at an odd byte address spans both banks at two different word addresses, so the block issues it as two byte cycles. The low byte goes first, at the given address. The high byte follows at the next address. On reads the block moves each byte to its place in the returned word. A one-clock done pulse marks the end of the whole request.

Top module: `lane_bank_ctrl`

## Requirements
- R1: After reset, and whenever no request is in progress, busy, done, mem_rd and mem_wr are 0 and both bank enables (mem_hi_n, mem_lo_n) are 1, which selects neither bank.
- R2: During a cycle, mem_addr equals the cycle's byte address bits 19:1. The enable pair {mem_hi_n, mem_lo_n} is 00 for a word at an even address, 10 for a byte at an even address and 01 for a byte at an odd address. It is never 11 while busy.
- R3: The odd bank uses mem_wdata[15:8] and mem_rdata[15:8], and the even bank uses bits 7:0. An aligned word write drives req_wdata unchanged. A byte cycle drives its byte on both lanes.
- R4: A word request at an odd address takes two cycles. The first uses the given address with enables 01 and carries the low byte. The second uses the address plus one, wrapping within 20 bits, with enables 10, and carries the high byte.
- R5: A byte read returns its byte on rdata[7:0] with rdata[15:8] = 0, whichever lane the byte came on. A word read returns the byte at the address on bits 7:0 and the byte at the address plus one on bits 15:8, for both alignments. Writes leave rdata unchanged.
- R6: Each cycle spends exactly one address clock and then data clocks until mem_ready is sampled high in a data clock. A zero-wait cycle lasts 2 clocks and each low-ready data clock adds one. mem_addr and the enables stay stable for the whole cycle.
- R7: done is high for exactly one clock, in the clock after the edge that completes the final cycle of the request, and busy is 0 in that clock. An aligned request with no wait states shows done 3 clocks after the request is presented.
- R8: A request presented while busy is ignored. The cycle in progress keeps its address and enables, and the ignored request never reaches memory.
- R9: mem_rd is asserted throughout the cycles of a read request and mem_wr throughout the cycles of a write request. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; accepted only when idle |
| req_addr | input | 20 | Byte address of the request |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; a byte uses bits 7:0 |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-clock pulse when the request has finished |
| rdata | output | 16 | Assembled read data, valid with done |
| mem_addr | output | 19 | Word address shared by both banks |
| mem_hi_n | output | 1 | Odd-bank enable, active low |
| mem_lo_n | output | 1 | Even-bank enable, active low |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_rdata | input | 16 | Read data from the banks |
| mem_ready | input | 1 | Memory ready; low in a data clock inserts a wait state |

## Verification
Several properties are checked on every clock. The outputs stay quiet while idle, and the enable pair is legal during a cycle. The strobes are exclusive. The address clock lasts a single clock. The address and enables hold through wait states and through a presented-but-ignored request, and done is a single pulse that follows a completed data clock. Only the bench scenarios can show the values. These include the lane code and address chosen for each size and alignment, the byte order of a split access (including the wrap from the top address to zero), the steering of read data, and memory contents that match a reference byte array under random ready stalls.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_T1   = 2'd1,
    ST_T2   = 2'd2
  } bus_st_e;
endpackage

// File: rtl/lbc_rst_sync.sv
module lbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/lbc_seq.sv
module lbc_seq
  import lbc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_fire,
  input  logic    split,
  input  logic    mem_ready,
  output bus_st_e state_q,
  output logic    phase_q,
  output logic    xfer_done,
  output logic    done
);
  bus_st_e state_d;
  logic    phase_d;
  logic    last_xfer;
  logic    done_d;

  always_comb begin
    xfer_done = (state_q == ST_T2) && mem_ready;
    last_xfer = !(split && !phase_q);
    done_d    = xfer_done && last_xfer;
    state_d   = state_q;
    phase_d   = phase_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_fire) begin
          state_d = ST_T1;
          phase_d = 1'b0;
        end
      end
      ST_T1: state_d = ST_T2;
      ST_T2: begin
        if (xfer_done) begin
          if (last_xfer) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_T1;
            phase_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      done    <= done_d;
    end
  end
endmodule

// File: rtl/lbc_lane_plan.sv
module lbc_lane_plan #(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic [ADDR_W-1:0]   addr_q,
  input  logic                word_q,
  input  logic                phase_q,
  input  logic [2*BYTE_W-1:0] wdata_q,
  output logic [ADDR_W-2:0]   word_addr,
  output logic                hi_n,
  output logic                lo_n,
  output logic                aligned_word,
  output logic                odd_lane,
  output logic [2*BYTE_W-1:0] wlanes
);
  localparam int DATA_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] eff_addr;
  logic [BYTE_W-1:0] byte_sel;

  always_comb begin
    // second half of a split access targets the next byte address
    eff_addr     = addr_q + {{(ADDR_W-1){1'b0}}, phase_q};
    aligned_word = word_q && !addr_q[0];
    odd_lane     = eff_addr[0];
    byte_sel     = phase_q ? wdata_q[DATA_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
    hi_n         = aligned_word ? 1'b0 : !odd_lane;
    lo_n         = aligned_word ? 1'b0 : odd_lane;
    wlanes       = aligned_word ? wdata_q : {byte_sel, byte_sel};
    word_addr    = eff_addr[ADDR_W-1:1];
  end
endmodule

// File: rtl/lbc_rd_merge.sv
module lbc_rd_merge #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic                aligned_word,
  input  logic                phase_q,
  input  logic                odd_lane,
  input  logic [2*BYTE_W-1:0] mem_rdata,
  output logic [2*BYTE_W-1:0] rdata_q
);
  localparam int DATA_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lane_byte;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    lane_byte = odd_lane ? mem_rdata[DATA_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0];
    rdata_d   = rdata_q;
    if (cap_en) begin
      if (aligned_word)  rdata_d = mem_rdata;
      else if (phase_q)  rdata_d[DATA_W-1:BYTE_W] = lane_byte;
      else               rdata_d = {{BYTE_W{1'b0}}, lane_byte};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
endmodule

// File: rtl/lane_bank_ctrl.sv
module lane_bank_ctrl
  import lbc_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_word,
  input  logic                req_write,
  input  logic [2*BYTE_W-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [2*BYTE_W-1:0] rdata,
  output logic [ADDR_W-2:0]   mem_addr,
  output logic                mem_hi_n,
  output logic                mem_lo_n,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [2*BYTE_W-1:0] mem_wdata,
  input  logic [2*BYTE_W-1:0] mem_rdata,
  input  logic                mem_ready
);
  localparam int DATA_W = 2 * BYTE_W;

  logic              rst_core_n;
  bus_st_e           state_q;
  logic              phase_q;
  logic              xfer_done;
  logic              req_fire;
  logic              active;
  logic              split;
  logic [ADDR_W-1:0] addr_q;
  logic              word_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic              hi_n_p;
  logic              lo_n_p;
  logic              aligned_word;
  logic              odd_lane;

  lbc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign req_fire = req_valid && (state_q == ST_IDLE);
  assign split    = word_q && addr_q[0];
  assign active   = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      addr_q  <= '0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (req_fire) begin
      addr_q  <= req_addr;
      word_q  <= req_word;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  lbc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_fire  (req_fire),
    .split     (split),
    .mem_ready (mem_ready),
    .state_q   (state_q),
    .phase_q   (phase_q),
    .xfer_done (xfer_done),
    .done      (done)
  );

  lbc_lane_plan #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_plan (
    .addr_q       (addr_q),
    .word_q       (word_q),
    .phase_q      (phase_q),
    .wdata_q      (wdata_q),
    .word_addr    (mem_addr),
    .hi_n         (hi_n_p),
    .lo_n         (lo_n_p),
    .aligned_word (aligned_word),
    .odd_lane     (odd_lane),
    .wlanes       (mem_wdata)
  );

  lbc_rd_merge #(.BYTE_W(BYTE_W)) u_merge (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .cap_en       (xfer_done && !write_q),
    .aligned_word (aligned_word),
    .phase_q      (phase_q),
    .odd_lane     (odd_lane),
    .mem_rdata    (mem_rdata),
    .rdata_q      (rdata)
  );

  assign busy     = active;
  assign mem_hi_n = !active || hi_n_p;
  assign mem_lo_n = !active || lo_n_p;
  assign mem_rd   = active && !write_q;
  assign mem_wr   = active && write_q;
endmodule

// File: rtl/lbc_checker.sv
module lbc_checker
  import lbc_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_hi_n,
  input logic              mem_lo_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic [ADDR_W-2:0] mem_addr,
  input bus_st_e           st
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_hi_n && mem_lo_n && !mem_rd && !mem_wr));

  p_lane_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(mem_hi_n && mem_lo_n));

  p_addr_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T1) |=> (st == ST_T2));

  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T2 && !mem_ready) |=>
      (st == ST_T2 && $stable(mem_addr) && $stable(mem_hi_n) && $stable(mem_lo_n)));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T1) |=>
      ($stable(mem_addr) && $stable(mem_hi_n) && $stable(mem_lo_n) && $stable(mem_rd)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st == ST_T2 && mem_ready));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_rd != mem_wr));
endmodule

bind lane_bank_ctrl lbc_checker #(.ADDR_W(ADDR_W)) u_lbc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mem_hi_n  (mem_hi_n),
  .mem_lo_n  (mem_lo_n),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .st        (state_q)
);

// File: tb/lane_bank_ctrl_bench.sv
module lane_bank_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [19:0] req_addr;
  logic        req_word;
  logic        req_write;
  logic [15:0] req_wdata;
  logic        busy;
  logic        done;
  logic [15:0] rdata;
  logic [18:0] mem_addr;
  logic        mem_hi_n;
  logic        mem_lo_n;
  logic        mem_rd;
  logic        mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ready;

  logic        rand_rdy;
  logic        man_rdy;
  logic [7:0]  lfsr;
  logic [7:0]  mdl [256];
  logic [7:0]  refm [256];
  int          n_chk;
  int          n_err;

  lane_bank_ctrl u_lane_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_hi_n(mem_hi_n), .mem_lo_n(mem_lo_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // two-bank memory model, indexed by the low 8 byte-address bits
  assign mem_rdata = {mdl[{mem_addr[6:0], 1'b1}], mdl[{mem_addr[6:0], 1'b0}]};
  assign mem_ready = rand_rdy ? (lfsr[0] | lfsr[1]) : man_rdy;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mdl[i] <= 8'(i * 37 + 5);
    end else if (mem_wr && mem_ready) begin
      if (!mem_hi_n) mdl[{mem_addr[6:0], 1'b1}] <= mem_wdata[15:8];
      if (!mem_lo_n) mdl[{mem_addr[6:0], 1'b0}] <= mem_wdata[7:0];
    end
  end

  always @(negedge clk) begin
    if (!rst_n) lfsr <= 8'h5D;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  // {write, word, addr[19:0], data[15:0]}
  localparam logic [37:0] VEC [14] = '{
    {1'b1, 1'b0, 20'h00010, 16'h00A5},
    {1'b1, 1'b0, 20'h00013, 16'h003C},
    {1'b1, 1'b1, 20'h00020, 16'hBEEF},
    {1'b1, 1'b1, 20'h00031, 16'h1234},
    {1'b1, 1'b1, 20'hFFFFF, 16'hCAFE},
    {1'b0, 1'b0, 20'h00010, 16'h0000},
    {1'b0, 1'b0, 20'h00013, 16'h0000},
    {1'b0, 1'b1, 20'h00020, 16'h0000},
    {1'b0, 1'b1, 20'h00031, 16'h0000},
    {1'b0, 1'b1, 20'hFFFFF, 16'h0000},
    {1'b0, 1'b0, 20'h00000, 16'h0000},
    {1'b0, 1'b1, 20'h00012, 16'h0000},
    {1'b1, 1'b0, 20'h00021, 16'h0077},
    {1'b0, 1'b1, 20'h00020, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input bit wd, input logic [19:0] a,
                        input logic [15:0] d, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic logic [15:0] exp_read(input bit wd, input logic [19:0] a);
    logic [7:0] ix;
    ix = a[7:0];
    if (wd) return {refm[8'(ix + 8'd1)], refm[ix]};
    return {8'h00, refm[ix]};
  endfunction

  task automatic ref_write(input bit wd, input logic [19:0] a, input logic [15:0] d);
    refm[a[7:0]] = d[7:0];
    if (wd) refm[8'(a[7:0] + 8'd1)] = d[15:8];
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R7 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int lat;
    logic [37:0] v;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_word = 1'b0;
    req_write = 1'b0; req_wdata = '0; rand_rdy = 1'b0; man_rdy = 1'b1;
    for (int i = 0; i < 256; i++) refm[i] = 8'(i * 37 + 5);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 enables after reset", 32'({mem_hi_n, mem_lo_n}), 32'h3);
    chk("R1 strobes after reset", 32'({mem_rd, mem_wr}), 32'h0);

    // table walk with random ready stalls (R3, R4, R5 readback)
    rand_rdy = 1'b1;
    for (int i = 0; i < 14; i++) begin
      v = VEC[i];
      do_req(v[37], v[36], v[35:16], v[15:0], lat);
      chk("R7 done seen for table entry", 32'(done), 32'd1);
      if (v[37]) begin
        ref_write(v[36], v[35:16], v[15:0]);
      end else if (v[36] && v[16]) begin
        chk("R4 split word read data", 32'(rdata), 32'(exp_read(1'b1, v[35:16])));
      end else begin
        chk("R5 read data", 32'(rdata), 32'(exp_read(v[36], v[35:16])));
      end
    end
    rand_rdy = 1'b0;
    man_rdy = 1'b1;

    // R2 R6 R7 aligned word read, zero wait
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_addr = 20'h00020;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 aligned word enables", 32'({mem_hi_n, mem_lo_n}), 32'h0);
    chk("R2 aligned word address", 32'(mem_addr), 32'h10);
    chk("R9 read strobes", 32'({mem_rd, mem_wr}), 32'h2);
    @(negedge clk);
    chk("R6 no done in data clock", 32'(done), 32'd0);
    @(negedge clk);
    chk("R7 done after zero-wait cycle", 32'({done, busy}), 32'h2);
    chk("R5 aligned word read", 32'(rdata), 32'(exp_read(1'b1, 20'h00020)));
    @(negedge clk);
    chk("R7 done is one clock", 32'(done), 32'd0);
    chk("R1 idle enables", 32'({mem_hi_n, mem_lo_n}), 32'h3);

    // R2 R6 odd byte read with one wait state
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b0; req_addr = 20'h00013;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 odd byte enables", 32'({mem_hi_n, mem_lo_n}), 32'h1);
    man_rdy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 wait state holds cycle", 32'({done, busy, mem_hi_n, mem_lo_n}), 32'h5);
    chk("R6 address held in wait", 32'(mem_addr), 32'h09);
    man_rdy = 1'b1;
    @(negedge clk);
    chk("R6 done after one wait", 32'(done), 32'd1);
    chk("R5 odd byte moved to low lane", 32'(rdata), 32'(exp_read(1'b0, 20'h00013)));

    // even byte write lane code and steering
    do_req(1'b1, 1'b0, 20'h00062, 16'hFF4D, lat);
    ref_write(1'b0, 20'h00062, 16'hFF4D);
    chk("R6 zero-wait latency", 32'(lat), 32'd3);

    // R4 R3 R8 R9 odd word write, with an ignored request during the cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1; req_addr = 20'h00041;
    req_wdata = 16'h9A5B;
    @(negedge clk);
    req_addr = 20'h00050; req_word = 1'b0; req_wdata = 16'h00EE;
    chk("R4 first half enables", 32'({mem_hi_n, mem_lo_n}), 32'h1);
    chk("R4 first half address", 32'(mem_addr), 32'h20);
    chk("R3 low byte on odd lane", 32'(mem_wdata[15:8]), 32'h5B);
    chk("R9 write strobes", 32'({mem_rd, mem_wr}), 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 address kept while busy", 32'(mem_addr), 32'h20);
    @(negedge clk);
    chk("R4 second half enables", 32'({mem_hi_n, mem_lo_n}), 32'h2);
    chk("R4 second half address", 32'(mem_addr), 32'h21);
    chk("R3 high byte on even lane", 32'(mem_wdata[7:0]), 32'h9A);
    chk("R7 no done between halves", 32'({done, busy}), 32'h1);
    @(negedge clk);
    @(negedge clk);
    chk("R7 done after split", 32'(done), 32'd1);
    ref_write(1'b1, 20'h00041, 16'h9A5B);

    do_req(1'b0, 1'b1, 20'h00041, 16'h0000, lat);
    chk("R4 split write readback", 32'(rdata), 32'(exp_read(1'b1, 20'h00041)));
    do_req(1'b0, 1'b0, 20'h00050, 16'h0000, lat);
    chk("R8 ignored request left memory", 32'(rdata), 32'(exp_read(1'b0, 20'h00050)));
    do_req(1'b0, 1'b1, 20'h00062, 16'h0000, lat);
    chk("R3 even byte write readback", 32'(rdata), 32'(exp_read(1'b1, 20'h00062)));
    do_req(1'b1, 1'b1, 20'h00070, 16'h1111, lat);
    chk("R5 write leaves rdata", 32'(rdata), 32'(exp_read(1'b1, 20'h00062)));
    ref_write(1'b1, 20'h00070, 16'h1111);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule